// File: doc/BRIEF.md
# Fault Collection and Escalation Controller

This block gathers a vector of critical fault inputs into sticky flags and runs a four-state machine (Init, Normal, Alarm, Fault). The machine escalates according to a two-bit reaction code held for each fault. A self-test mode lets software inject fake faults while real inputs are masked. That mode can only be switched on while the machine is still in Init.

A freeze copy of the flags and of a sampled system-state input is kept whenever a new flag appears. A non-destructive (soft) reset leaves the freeze copy untouched, so software can read it after the reset. Only a destructive (hard) reset clears it. Flags are cleared through a guarded sequence: a key write arms the clear, and the very next register access must be the write-one-to-clear to the flag register.

Besides the fault inputs, the flags include one software fault. Software raises it by writing the top bit of the fake-fault register from 0 to 1 outside Init. All configuration goes through a simple strobed register write/read port whose read data is combinational.

Top module: `fault_escalator`

## Requirements
- R1: After either reset the state is Init (state_o = 0). The flags, test bit, reaction codes, timeout, fake register and clear guard are all zero.
- R2: Outside test mode, an input fault_in[i] that is high at a clock edge sets flag i (address 3, bit i) at that edge. The flag stays set after the input falls.
- R3: Reaction codes sit at address 1, bits [2i+1:2i] for flag i, and flag index NFAULT is the software fault. Code 0 ignores the flag. Code 1 moves Normal to Alarm. Code 2 moves Normal or Alarm to Fault. Code 3 moves Normal to Alarm with later escalation. A set flag changes the state on the following edge.
- R4: With a code-3 flag set, the machine stays in Alarm for exactly TMO+1 cycles and then enters Fault, where TMO is the value at address 2. It returns from Alarm to Normal once no code-1 or code-3 flag is set.
- R5: Control bit 0 (test enable, address 0) can only be set while in Init. Elsewhere, writing 1 to it leaves it at 0. Control read data holds the test bit in bit 0 and the state in bits [5:4].
- R6: In test mode fault_in is ignored, and bits [NFAULT-1:0] of the fake-fault register (address 5) are latched into the flags instead.
- R7: Writing 0 to the test bit while in test mode clears every flag.
- R8: The software fault flag is set only when a write to address 5 takes bit NFAULT from 0 to 1 outside Init. A 1 written in Init is never latched, and neither is a later re-write of 1.
- R9: A flag-register write clears the flags written as 1 only when the access just before it was a write of CLR_KEY to address 4. Any other access in between, or an unarmed write, leaves the flags unchanged.
- R10: Fault is left, to Normal, only on the edge after all flags read zero.
- R11: The system-state input is sampled every cycle and can be read at address 8. When a flag newly sets, the freeze registers capture the flags (address 6) and the sampled state (address 7). A soft reset keeps them; a hard reset clears them.
- R12: Writing 1 to control bit 1 while in Init moves the state to Normal on that edge. Init is left no other way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_hard_n | input | 1 | Destructive reset, asynchronous, active low |
| rst_soft_n | input | 1 | Non-destructive reset, synchronous, active low |
| fault_in | input | NFAULT | Fault inputs, sampled each edge |
| sys_state_in | input | SYS_W | System-state input, sampled every cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (counts as an access for the clear guard) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on reg_addr |
| state_o | output | 2 | State: 0 Init, 1 Normal, 2 Alarm, 3 Fault |
| alarm_o | output | 1 | High in Alarm |
| fault_o | output | 1 | High in Fault |

## Verification
The assertions watch several rules on every cycle. Test mode may rise only out of Init, and flags read zero after test mode ends. A flag may drop only after an armed clear or a test exit. Fault holds while any flag is set, Init holds until a run write, and a soft reset never disturbs the freeze copy.

Some behaviour only the bench scenarios can show. These are the exact Alarm dwell before escalation, the masking of real faults in test mode, and the software-fault edge rule across Init and Normal. They also include the abort of the clear guard by an intervening read, and the freeze contents read back after a soft reset.

// File: rtl/fault_escalator.sv
module fault_escalator #(
  parameter int NFAULT = 8,
  parameter int SYS_W = 4,
  parameter int TMO_W = 16,
  parameter logic [31:0] CLR_KEY = 32'h0000_C1EA
) (
  input  logic              clk,
  input  logic              rst_hard_n,
  input  logic              rst_soft_n,
  input  logic [NFAULT-1:0] fault_in,
  input  logic [SYS_W-1:0]  sys_state_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [1:0]        state_o,
  output logic              alarm_o,
  output logic              fault_o
);

  localparam int NF1 = NFAULT + 1;
  localparam int SWB = NFAULT;
  localparam int RW  = 2 * NF1;

  localparam logic [3:0] A_CTRL = 4'd0, A_REACT = 4'd1, A_TMO = 4'd2, A_FLAGS = 4'd3,
                         A_KEY = 4'd4, A_FAKE = 4'd5, A_FRZF = 4'd6, A_FRZS = 4'd7,
                         A_LIVE = 4'd8;

  typedef enum logic [1:0] {ST_INIT = 2'd0, ST_NORMAL = 2'd1, ST_ALARM = 2'd2, ST_FAULT = 2'd3} st_t;

  st_t              state_q, state_d;
  logic             test_q, armed_q;
  logic [NF1-1:0]   flags_q, flags_d, fake_q, set_v, frz_flags_q;
  logic [RW-1:0]    react_q;
  logic [TMO_W-1:0] tmo_q, cnt_q;
  logic [SYS_W-1:0] sys_q, frz_sys_q;
  logic [NF1-1:0]   is_f, is_a, is_t;

  wire access    = reg_wr | reg_rd;
  wire wr_ctrl   = reg_wr && reg_addr == A_CTRL;
  wire wr_flags  = reg_wr && reg_addr == A_FLAGS;
  wire wr_fake   = reg_wr && reg_addr == A_FAKE;
  wire wr_key    = reg_wr && reg_addr == A_KEY;
  wire run_req   = wr_ctrl && reg_wdata[1];
  wire clr_ok    = armed_q && wr_flags;
  wire test_exit = test_q && wr_ctrl && !reg_wdata[0];
  wire sw_pulse  = wr_fake && reg_wdata[SWB] && !fake_q[SWB] && state_q != ST_INIT;

  assign set_v   = {sw_pulse, test_q ? fake_q[NFAULT-1:0] : fault_in};
  assign flags_d = test_exit ? '0
                 : (flags_q & ~(clr_ok ? reg_wdata[NF1-1:0] : '0)) | set_v;

  for (genvar i = 0; i < NF1; i++) begin : g_react
    wire [1:0] code = react_q[2*i +: 2];
    assign is_f[i] = flags_q[i] && code == 2'd2;
    assign is_a[i] = flags_q[i] && code[0];
    assign is_t[i] = flags_q[i] && code == 2'd3;
  end

  wire want_f = |is_f;
  wire want_a = |is_a;
  wire want_t = |is_t;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_INIT:   if (run_req) state_d = ST_NORMAL;
      ST_NORMAL: if (want_f) state_d = ST_FAULT;
                 else if (want_a) state_d = ST_ALARM;
      ST_ALARM:  if (want_f || (want_t && cnt_q == tmo_q)) state_d = ST_FAULT;
                 else if (!want_a) state_d = ST_NORMAL;
      default:   if (flags_q == '0) state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_hard_n) begin
    if (!rst_hard_n || !rst_soft_n) begin
      state_q <= ST_INIT;
      test_q  <= 1'b0;
      armed_q <= 1'b0;
      flags_q <= '0;
      fake_q  <= '0;
      react_q <= '0;
      tmo_q   <= '0;
      cnt_q   <= '0;
      sys_q   <= '0;
    end else begin
      state_q <= state_d;
      flags_q <= flags_d;
      sys_q   <= sys_state_in;
      cnt_q   <= (state_q == ST_ALARM && want_t) ? cnt_q + 1'b1 : '0;
      if (access) armed_q <= wr_key && reg_wdata == CLR_KEY;
      if (wr_ctrl) test_q <= reg_wdata[0] & (test_q | state_q == ST_INIT);
      if (wr_fake) fake_q <= reg_wdata[NF1-1:0];
      if (reg_wr && reg_addr == A_REACT) react_q <= reg_wdata[RW-1:0];
      if (reg_wr && reg_addr == A_TMO) tmo_q <= reg_wdata[TMO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_hard_n) begin
    if (!rst_hard_n) begin
      frz_flags_q <= '0;
      frz_sys_q   <= '0;
    end else if (rst_soft_n && |(set_v & ~flags_q)) begin
      frz_flags_q <= flags_q | set_v;
      frz_sys_q   <= sys_q;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  begin reg_rdata[0] = test_q; reg_rdata[5:4] = state_q; end
      A_REACT: reg_rdata[RW-1:0] = react_q;
      A_TMO:   reg_rdata[TMO_W-1:0] = tmo_q;
      A_FLAGS: reg_rdata[NF1-1:0] = flags_q;
      A_FAKE:  reg_rdata[NF1-1:0] = fake_q;
      A_FRZF:  reg_rdata[NF1-1:0] = frz_flags_q;
      A_FRZS:  reg_rdata[SYS_W-1:0] = frz_sys_q;
      A_LIVE:  reg_rdata[SYS_W-1:0] = sys_q;
      default: reg_rdata = '0;
    endcase
  end

  assign state_o = state_q;
  assign alarm_o = state_q == ST_ALARM;
  assign fault_o = state_q == ST_FAULT;

  assert_test_from_init_R5: assert property (@(posedge clk) disable iff (!rst_hard_n || !rst_soft_n)
    $rose(test_q) |-> $past(state_q) == ST_INIT);

  assert_test_exit_clears_R7: assert property (@(posedge clk) disable iff (!rst_hard_n || !rst_soft_n)
    $fell(test_q) |-> flags_q == '0);

  assert_flag_drop_guarded_R9: assert property (@(posedge clk) disable iff (!rst_hard_n || !rst_soft_n)
    ($past(rst_soft_n) && |($past(flags_q) & ~flags_q)) |-> ($past(clr_ok) || $past(test_exit)));

  assert_fault_hold_R10: assert property (@(posedge clk) disable iff (!rst_hard_n || !rst_soft_n)
    (state_q == ST_FAULT && flags_q != '0) |=> state_q == ST_FAULT);

  assert_init_hold_R12: assert property (@(posedge clk) disable iff (!rst_hard_n || !rst_soft_n)
    (state_q == ST_INIT && !run_req) |=> state_q == ST_INIT);

  assert_freeze_kept_R11: assert property (@(posedge clk) disable iff (!rst_hard_n)
    !rst_soft_n |=> ($stable(frz_flags_q) && $stable(frz_sys_q)));

endmodule

// File: tb/fault_escalator_tb.sv
module fault_escalator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h0000_C1EA;

  logic clk = 0, rst_hard_n = 0, rst_soft_n = 1;
  logic [7:0] fault_in = '0;
  logic [3:0] sys_state_in = 4'hA;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [1:0] state_o;
  logic alarm_o, fault_o;
  int checks = 0, failures = 0;
  logic [31:0] d;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_escalator dut_i (.clk(clk), .rst_hard_n(rst_hard_n), .rst_soft_n(rst_soft_n),
    .fault_in(fault_in), .sys_state_in(sys_state_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .state_o(state_o), .alarm_o(alarm_o), .fault_o(fault_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic pulse(input logic [7:0] f);
    @(negedge clk); fault_in = f;
    @(negedge clk); fault_in = '0;
  endtask

  task automatic guarded_clear(input logic [31:0] m);
    wr(4'd4, KEY); wr(4'd3, m);
  endtask

  task automatic t_reset();
    tick(2); rst_hard_n = 1; tick(1);
    chk("R1 state", 32'(state_o), 0);
    rd(4'd3, d); chk("R1 flags", d, 0);
    rd(4'd0, d); chk("R1 ctrl", d, 0);
  endtask

  task automatic t_test_mode();
    wr(4'd0, 32'h1);
    rd(4'd0, d); chk("R5 test set in Init", d, 32'h1);
    fault_in = 8'hFF; tick(2); fault_in = '0;
    rd(4'd3, d); chk("R6 real faults masked", d, 0);
    wr(4'd5, 32'h05);
    rd(4'd3, d); chk("R6 fake faults latched", d, 32'h005);
    wr(4'd0, 32'h0);
    rd(4'd3, d); chk("R7 exit clears flags", d, 0);
    wr(4'd5, 32'h0);
  endtask

  task automatic t_sw_init_and_run();
    wr(4'd5, 32'h100);
    rd(4'd3, d); chk("R8 sw bit in Init not latched", d, 0);
    wr(4'd0, 32'h2);
    chk("R12 run to Normal", 32'(state_o), 1);
    wr(4'd5, 32'h100);
    rd(4'd3, d); chk("R8 rewrite of 1 not latched", d, 0);
  endtask

  task automatic t_test_outside_init();
    wr(4'd0, 32'h1);
    rd(4'd0, d); chk("R5 test refused in Normal", d, 32'h10);
  endtask

  task automatic t_latch();
    pulse(8'h08);
    rd(4'd3, d); chk("R2 flag latched", d, 32'h008);
    tick(3);
    rd(4'd3, d); chk("R2 flag sticky", d, 32'h008);
    chk("R3 code 0 ignored", 32'(state_o), 1);
  endtask

  task automatic t_guard();
    wr(4'd3, 32'h08);
    rd(4'd3, d); chk("R9 unarmed write ignored", d, 32'h008);
    wr(4'd4, KEY); rd(4'd0, d); wr(4'd3, 32'h08);
    rd(4'd3, d); chk("R9 read aborts guard", d, 32'h008);
    wr(4'd4, 32'h1234); wr(4'd3, 32'h08);
    rd(4'd3, d); chk("R9 wrong key", d, 32'h008);
    guarded_clear(32'h08);
    rd(4'd3, d); chk("R9 guarded clear", d, 0);
  endtask

  task automatic t_fault();
    wr(4'd1, 32'h8);
    pulse(8'h06); tick(1);
    chk("R3 code 2 to Fault", 32'(fault_o), 1);
    rd(4'd6, d); chk("R11 freeze flags", d, 32'h006);
    rd(4'd7, d); chk("R11 freeze sys state", d, 32'hA);
    guarded_clear(32'h02); tick(2);
    chk("R10 stays Fault with flag left", 32'(state_o), 3);
    guarded_clear(32'h04); tick(2);
    chk("R10 back to Normal", 32'(state_o), 1);
  endtask

  task automatic t_alarm();
    int cnt;
    wr(4'd1, 32'hD00); wr(4'd2, 32'd5);
    pulse(8'h10); tick(1);
    chk("R3 code 1 to Alarm", 32'(state_o), 2);
    guarded_clear(32'h10); tick(2);
    chk("R4 Alarm returns to Normal", 32'(state_o), 1);
    pulse(8'h20);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (alarm_o) cnt++;
      if (fault_o) break;
    end
    chk("R4 Alarm dwell TMO+1", 32'(cnt), 6);
    chk("R4 escalated to Fault", 32'(fault_o), 1);
    guarded_clear(32'h20); tick(2);
    chk("R4 cleared to Normal", 32'(state_o), 1);
  endtask

  task automatic t_soft();
    @(negedge clk); rst_soft_n = 0; tick(2); rst_soft_n = 1; tick(1);
    chk("R1 soft reset state", 32'(state_o), 0);
    rd(4'd1, d); chk("R1 reaction reset", d, 0);
    rd(4'd6, d); chk("R11 freeze kept over soft reset", d, 32'h020);
  endtask

  task automatic t_sw_normal();
    wr(4'd0, 32'h2);
    wr(4'd5, 32'h100);
    rd(4'd3, d); chk("R8 sw fault latched in Normal", d, 32'h100);
    sys_state_in = 4'h5; tick(2);
    rd(4'd8, d); chk("R11 live sys state", d, 32'h5);
  endtask

  task automatic t_hard();
    @(negedge clk); rst_hard_n = 0; tick(2); rst_hard_n = 1; tick(1);
    rd(4'd6, d); chk("R11 hard reset clears freeze", d, 0);
    rd(4'd7, d); chk("R11 hard reset clears freeze state", d, 0);
  endtask

  initial begin
    t_reset();
    t_test_mode();
    t_sw_init_and_run();
    t_test_outside_init();
    t_latch();
    t_guard();
    t_fault();
    t_alarm();
    t_soft();
    t_sw_normal();
    t_hard();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule